// File: doc/BRIEF.md
# Eight-Slot Time-Division SRAM Arbiter

This block lets four internal clients share one byte-wide external static RAM. The RAM performs one access per system clock. A fixed schedule of eight slots repeats without end, and each slot belongs to exactly one client. Five slots serve the event-accumulation client. The histogram-readout client, the host table-write client and the waveform-table reader get one slot each. A slot whose owner is not requesting goes idle: the RAM is left deselected and no other client may use that cycle. This makes every client's bandwidth and latency fixed, whatever the other clients are doing.

The external RAM is four times larger than the window a client can address. A bank-select command picks which quarter of the RAM all clients reach. The new bank takes effect only at a schedule boundary, so a complete frame of eight slots always uses a single bank. Reads use a simple asynchronous RAM model: the data on the RAM data input during the slot is registered and returned to the client one clock later, with a one-cycle valid pulse on that client's bit.

The schedule is a state machine with eight named states, taken in this order: `SL_ACC0`, `SL_ACC1`, `SL_ACC2`, `SL_ACC3`, `SL_ACC4`, `SL_READOUT`, `SL_TBLWR`, `SL_WAVE`. Each state moves unconditionally to the next state in the list. `SL_WAVE` wraps back to `SL_ACC0`. Reset forces `SL_ACC0`.

Top module: `tdm_sram_arbiter`

## Requirements
- R1: After reset is released, the first clock cycle is slot 0. The slot advances by one every clock, through slots 0 to 7, and wraps from 7 back to 0.
- R2: Client bit 0 (accumulation) owns slots 0 to 4. Client bit 1 (readout) owns slot 5. Client bit 2 (table write) owns slot 6. Client bit 3 (waveform read) owns slot 7.
- R3: In a given cycle, a grant is asserted only to the owner of the current slot, and only when that owner's request is high. It is asserted in that same cycle, and at most one grant bit is ever high.
- R4: When the slot owner is not requesting, the cycle is idle. No grant is asserted, the active-low chip enable, output enable and write enable are all high, and the slot is never passed to another client.
- R5: A granted read drives chip enable low, output enable low and write enable high, with the data output enable low. The RAM address is {active bank, owner's address}, with the bank in the top bits.
- R6: A granted write drives chip enable low, write enable low and output enable high. It raises the data output enable, drives the owner's write data on the RAM data output, and uses the same address layout as R5.
- R7: In the clock after a granted read, the read-data output holds the value that was on the RAM data input during the slot, and that client's valid bit is high for exactly that one cycle. Writes produce no valid pulse.
- R8: A bank-load strobe records the bank value. The recorded value becomes the active bank at the next entry to slot 0; a strobe during slot 7 takes effect in the very next cycle. If several strobes arrive before the boundary, the last one wins. At no other time does the active bank change.
- R9: Reset (active low, asynchronous) sets the active and recorded bank to 0 and clears all valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one RAM cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_load_i | input | 1 | Strobe recording a new bank value |
| bank_sel_i | input | BANK_W | Bank value recorded by the strobe |
| cl_req_i | input | 4 | Per-client request |
| cl_we_i | input | 4 | Per-client write enable (1 = write) |
| cl_addr_i | input | 4*ADDR_W | Per-client address, client c in bits [c*ADDR_W +: ADDR_W] |
| cl_wdata_i | input | 4*DATA_W | Per-client write data, client c in bits [c*DATA_W +: DATA_W] |
| cl_grant_o | output | 4 | Per-client grant in the slot cycle |
| cl_rdata_o | output | DATA_W | Returned read data |
| cl_rvalid_o | output | 4 | Per-client read-data valid pulse |
| ram_addr_o | output | BANK_W+ADDR_W | RAM address |
| ram_dq_o | output | DATA_W | RAM write data |
| ram_dq_oe_o | output | 1 | Drive enable for the RAM data pins |
| ram_dq_i | input | DATA_W | RAM read data |
| ram_ce_n_o | output | 1 | RAM chip enable, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |

## Verification
The bench sweeps all sixteen request patterns over two full frames each, so every slot meets both a requesting owner and an idle one. A design that handed an idle slot to another requester, or that granted one slot too early or too late, would fail on grants and strobes. A bank strobe is issued in each of the eight slots, and two strobes are also issued inside one frame. A design that switched banks mid-frame, missed the slot-7 case or kept the first of two strobes would show the wrong upper address bits. Reads that follow writes to the same byte, plus a mid-run reset, catch read data returned in the wrong cycle, to the wrong client or from a stale bank.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;
    localparam int NUM_CLIENTS = 4;
    localparam int CID_W       = 2;
    localparam int SLOT_W      = 3;

    typedef enum logic [CID_W-1:0] {
        CL_ACCUM   = 2'd0,
        CL_READOUT = 2'd1,
        CL_TBLWR   = 2'd2,
        CL_WAVE    = 2'd3
    } client_e;

    typedef enum logic [SLOT_W-1:0] {
        SL_ACC0    = 3'd0,
        SL_ACC1    = 3'd1,
        SL_ACC2    = 3'd2,
        SL_ACC3    = 3'd3,
        SL_ACC4    = 3'd4,
        SL_READOUT = 3'd5,
        SL_TBLWR   = 3'd6,
        SL_WAVE    = 3'd7
    } slot_e;
endpackage

// File: rtl/tdm_slot_fsm.sv
module tdm_slot_fsm
    import tdm_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    output slot_e   slot_q,
    output client_e owner,
    output logic    frame_end
);
    slot_e slot_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SL_ACC0;
        else        slot_q <= slot_d;
    end

    // next-state: fixed cyclic order
    always_comb begin
        slot_d = SL_ACC0;
        unique case (slot_q)
            SL_ACC0:    slot_d = SL_ACC1;
            SL_ACC1:    slot_d = SL_ACC2;
            SL_ACC2:    slot_d = SL_ACC3;
            SL_ACC3:    slot_d = SL_ACC4;
            SL_ACC4:    slot_d = SL_READOUT;
            SL_READOUT: slot_d = SL_TBLWR;
            SL_TBLWR:   slot_d = SL_WAVE;
            SL_WAVE:    slot_d = SL_ACC0;
        endcase
    end

    // outputs: slot ownership
    always_comb begin
        owner     = CL_ACCUM;
        frame_end = 1'b0;
        unique case (slot_q)
            SL_ACC0, SL_ACC1, SL_ACC2,
            SL_ACC3, SL_ACC4: owner = CL_ACCUM;
            SL_READOUT:       owner = CL_READOUT;
            SL_TBLWR:         owner = CL_TBLWR;
            SL_WAVE: begin
                owner     = CL_WAVE;
                frame_end = 1'b1;
            end
        endcase
    end

    assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SL_WAVE) |=> (slot_q == SL_ACC0));

    assert_slot_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != SL_WAVE) |=> (slot_q != SL_ACC0));
endmodule

// File: rtl/tdm_bank_reg.sv
module tdm_bank_reg #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BANK_W-1:0] sel_i,
    input  logic              frame_end_i,
    output logic [BANK_W-1:0] bank_q
);
    logic [BANK_W-1:0] pend_q;
    logic [BANK_W-1:0] pend_d;

    always_comb pend_d = load_i ? sel_i : pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            bank_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (frame_end_i) bank_q <= pend_d;
        end
    end

    assert_bank_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(bank_q));
endmodule

// File: rtl/tdm_access_mux.sv
module tdm_access_mux
    import tdm_arb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    localparam int RAM_AW = BANK_W + ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  client_e                       owner,
    input  logic [BANK_W-1:0]             bank,
    input  logic [NUM_CLIENTS-1:0]        cl_req,
    input  logic [NUM_CLIENTS-1:0]        cl_we,
    input  logic [NUM_CLIENTS*ADDR_W-1:0] cl_addr,
    input  logic [NUM_CLIENTS*DATA_W-1:0] cl_wdata,
    output logic [NUM_CLIENTS-1:0]        grant,
    output logic [NUM_CLIENTS-1:0]        rd_grant,
    output logic [RAM_AW-1:0]             ram_addr,
    output logic [DATA_W-1:0]             ram_dq,
    output logic                          ram_dq_oe,
    output logic                          ram_ce_n,
    output logic                          ram_oe_n,
    output logic                          ram_we_n
);
    logic [ADDR_W-1:0] addr_arr  [NUM_CLIENTS];
    logic [DATA_W-1:0] wdata_arr [NUM_CLIENTS];
    logic              access;
    logic              is_write;

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
        assign addr_arr[c]  = cl_addr[c*ADDR_W +: ADDR_W];
        assign wdata_arr[c] = cl_wdata[c*DATA_W +: DATA_W];
        assign grant[c]     = (owner == client_e'(CID_W'(c))) && cl_req[c];
        assign rd_grant[c]  = grant[c] && !cl_we[c];
    end

    always_comb begin
        access    = cl_req[owner];
        is_write  = access && cl_we[owner];
        ram_addr  = {bank, addr_arr[owner]};
        ram_dq    = wdata_arr[owner];
        ram_dq_oe = is_write;
        ram_ce_n  = !access;
        ram_we_n  = !is_write;
        ram_oe_n  = !(access && !cl_we[owner]);
    end

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_idle_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> (ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe));

    assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_oe_n && !ram_we_n));
endmodule

// File: rtl/tdm_read_return.sv
module tdm_read_return
    import tdm_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CLIENTS-1:0] rd_grant,
    input  logic [DATA_W-1:0]      ram_dq_i,
    output logic [DATA_W-1:0]      rdata_q,
    output logic [NUM_CLIENTS-1:0] rvalid_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= '0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_grant;
            if (|rd_grant) rdata_q <= ram_dq_i;
        end
    end

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_chk
        assert_read_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[c] |=> (rvalid_q[c] && rdata_q == $past(ram_dq_i)));
    end

    assert_rvalid_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rvalid_q));
endmodule

// File: rtl/tdm_sram_arbiter.sv
module tdm_sram_arbiter
    import tdm_arb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    localparam int RAM_AW = BANK_W + ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bank_load_i,
    input  logic [BANK_W-1:0]             bank_sel_i,
    input  logic [NUM_CLIENTS-1:0]        cl_req_i,
    input  logic [NUM_CLIENTS-1:0]        cl_we_i,
    input  logic [NUM_CLIENTS*ADDR_W-1:0] cl_addr_i,
    input  logic [NUM_CLIENTS*DATA_W-1:0] cl_wdata_i,
    output logic [NUM_CLIENTS-1:0]        cl_grant_o,
    output logic [DATA_W-1:0]             cl_rdata_o,
    output logic [NUM_CLIENTS-1:0]        cl_rvalid_o,
    output logic [RAM_AW-1:0]             ram_addr_o,
    output logic [DATA_W-1:0]             ram_dq_o,
    output logic                          ram_dq_oe_o,
    input  logic [DATA_W-1:0]             ram_dq_i,
    output logic                          ram_ce_n_o,
    output logic                          ram_oe_n_o,
    output logic                          ram_we_n_o
);
    slot_e                   slot_q;
    client_e                 owner;
    logic                    frame_end;
    logic [BANK_W-1:0]       bank;
    logic [NUM_CLIENTS-1:0]  rd_grant;

    tdm_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_q    (slot_q),
        .owner     (owner),
        .frame_end (frame_end)
    );

    tdm_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (bank_load_i),
        .sel_i       (bank_sel_i),
        .frame_end_i (frame_end),
        .bank_q      (bank)
    );

    tdm_access_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner     (owner),
        .bank      (bank),
        .cl_req    (cl_req_i),
        .cl_we     (cl_we_i),
        .cl_addr   (cl_addr_i),
        .cl_wdata  (cl_wdata_i),
        .grant     (cl_grant_o),
        .rd_grant  (rd_grant),
        .ram_addr  (ram_addr_o),
        .ram_dq    (ram_dq_o),
        .ram_dq_oe (ram_dq_oe_o),
        .ram_ce_n  (ram_ce_n_o),
        .ram_oe_n  (ram_oe_n_o),
        .ram_we_n  (ram_we_n_o)
    );

    tdm_read_return #(.DATA_W(DATA_W)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_grant (rd_grant),
        .ram_dq_i (ram_dq_i),
        .rdata_q  (cl_rdata_o),
        .rvalid_q (cl_rvalid_o)
    );

    // slot 5..7 owners never see a grant during accumulation slots
    assert_accum_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q <= SL_ACC4) |-> (cl_grant_o[3:1] == 3'b000));

    assert_idle_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_req_i[owner] |-> (cl_grant_o == '0));
endmodule

// File: tb/tdm_sram_arbiter_tb.sv
module tdm_sram_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int BANK_W = 2;
    localparam int RAM_AW = BANK_W + ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bank_load = 1'b0;
    logic [BANK_W-1:0] bank_sel = '0;
    logic [3:0] req = '0;
    logic [3:0] we = '0;
    logic [ADDR_W-1:0] a_addr [4];
    logic [DATA_W-1:0] a_wd [4];
    logic [4*ADDR_W-1:0] addr_flat;
    logic [4*DATA_W-1:0] wd_flat;
    logic [3:0] grant, rvalid;
    logic [DATA_W-1:0] rdata, dq_o, dq_i;
    logic [RAM_AW-1:0] ram_addr;
    logic dq_oe, ce_n, oe_n, we_n;
    logic [7:0] mem [64];

    int n_tests = 0;
    int n_fail = 0;
    int m_slot = 0;
    logic [1:0] m_bank = '0;
    logic [1:0] m_pend = '0;
    logic [3:0] exp_rv = '0;
    logic [7:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            addr_flat[c*ADDR_W +: ADDR_W] = a_addr[c];
            wd_flat[c*DATA_W +: DATA_W]   = a_wd[c];
        end
    end

    assign dq_i = mem[{ram_addr[RAM_AW-1 -: 2], ram_addr[3:0]}];

    always @(posedge clk)
        if (!ce_n && !we_n) mem[{ram_addr[RAM_AW-1 -: 2], ram_addr[3:0]}] <= dq_o;

    tdm_sram_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bank_load_i(bank_load), .bank_sel_i(bank_sel),
        .cl_req_i(req), .cl_we_i(we), .cl_addr_i(addr_flat), .cl_wdata_i(wd_flat),
        .cl_grant_o(grant), .cl_rdata_o(rdata), .cl_rvalid_o(rvalid),
        .ram_addr_o(ram_addr), .ram_dq_o(dq_o), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i),
        .ram_ce_n_o(ce_n), .ram_oe_n_o(oe_n), .ram_we_n_o(we_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int owner_of(input int s);
        return (s < 5) ? 0 : s - 4;
    endfunction

    // called right after a falling edge, inputs already set
    task automatic step();
        int o;
        logic [3:0] eg;
        logic [RAM_AW-1:0] ea;
        #1;
        o  = owner_of(m_slot);
        eg = req[o] ? 4'(1 << o) : 4'b0;
        chk(grant == eg, "R2/R3 grant", 32'(grant), 32'(eg));
        if (eg != 0) begin
            ea = {m_bank, a_addr[o]};
            chk(ram_addr == ea, "R5/R8 address", 32'(ram_addr), 32'(ea));
            chk(ce_n == 1'b0, "R5 chip enable", 32'(ce_n), 0);
            if (we[o]) begin
                chk({we_n, oe_n, dq_oe} == 3'b011, "R6 write strobes", 32'({we_n, oe_n, dq_oe}), 32'h3);
                chk(dq_o == a_wd[o], "R6 write data", 32'(dq_o), 32'(a_wd[o]));
            end else begin
                chk({we_n, oe_n, dq_oe} == 3'b100, "R5 read strobes", 32'({we_n, oe_n, dq_oe}), 32'h4);
            end
        end else begin
            chk({ce_n, oe_n, we_n, dq_oe} == 4'b1110, "R4 idle pins", 32'({ce_n, oe_n, we_n, dq_oe}), 32'he);
        end
        chk(rvalid == exp_rv, "R7 rvalid", 32'(rvalid), 32'(exp_rv));
        if (exp_rv != 0) chk(rdata == exp_rd, "R7 rdata", 32'(rdata), 32'(exp_rd));
        exp_rv = (eg != 0 && !we[o]) ? eg : 4'b0;
        exp_rd = dq_i;
        if (bank_load) m_pend = bank_sel;
        if (m_slot == 7) m_bank = m_pend;
        m_slot = (m_slot + 1) % 8;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0; we = '0; bank_load = 1'b0;
        repeat (3) @(negedge clk);
        chk(rvalid == 4'b0, "R9 rvalid in reset", 32'(rvalid), 0);
        m_slot = 0; m_bank = '0; m_pend = '0; exp_rv = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        for (int c = 0; c < 4; c++) begin
            a_addr[c] = ADDR_W'(c * 4 + 17'h100 * (c + 1));
            a_wd[c]   = 8'(8'h50 + c);
        end
        @(negedge clk);
        do_reset();
        // R4 R9: idle after reset, bank 0
        for (int i = 0; i < 8; i++) step();

        // R1 R2 R3 R4 R5 R7: all request patterns, reads
        for (int m = 0; m < 16; m++) begin
            req = 4'(m);
            for (int i = 0; i < 16; i++) begin
                for (int c = 0; c < 4; c++) a_addr[c][3:0] = 4'((c * 4 + i + m) % 16);
                step();
            end
        end

        // R6 R7: writes by clients 0 and 2, reads of same bytes by 1 and 3
        req = 4'hf; we = 4'b0101;
        for (int i = 0; i < 24; i++) begin
            a_addr[0][3:0] = 4'(i % 16);
            a_addr[2][3:0] = 4'((i + 5) % 16);
            a_addr[1][3:0] = 4'(i % 16);
            a_addr[3][3:0] = 4'((i + 5) % 16);
            a_wd[0] = 8'(8'hA0 + i);
            a_wd[2] = 8'(8'h30 + 3 * i);
            step();
        end
        we = '0;

        // R8: bank strobe in every slot
        for (int k = 0; k < 8; k++) begin
            while (m_slot != k) step();
            bank_sel = 2'((k + 1) % 4);
            bank_load = 1'b1;
            step();
            bank_load = 1'b0;
            for (int i = 0; i < 10; i++) step();
        end

        // R8: two strobes in one frame, last wins
        while (m_slot != 2) step();
        bank_sel = 2'd1; bank_load = 1'b1; step(); bank_load = 1'b0;
        step();
        bank_sel = 2'd2; bank_load = 1'b1; step(); bank_load = 1'b0;
        for (int i = 0; i < 12; i++) step();

        // R9: reset mid-run restores bank 0 and slot 0
        bank_sel = 2'd3; bank_load = 1'b1; step(); bank_load = 1'b0;
        for (int i = 0; i < 9; i++) step();
        do_reset();
        req = 4'hf;
        for (int i = 0; i < 16; i++) step();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule